// File: doc/BRIEF.md
# Banked CPU Bus Qualifier

This block sits between a processor with a 16-bit address bus and the memory and peripherals on its board. The processor shares its data bus with the upper address byte. While the phase-2 clock is low, the data pins carry the bank number. While it is high, they carry data. The block captures the bank byte during the low phase and joins it with the sixteen address lines to form a 24-bit address. It also gives the low 20 bits as the SRAM address.

From the full address the block decodes one of three regions: a page of I/O registers, a page of boot ROM, and a 1 MB SRAM area. A select asserts only when the processor marks the address valid for data or for program fetch, and only while the bus-enable input is high. Read and write strobes, and the data-transceiver direction, are gated by the high phase of phase-2. This keeps any device from driving the shared bus while the bank byte is on it. The phase-2 input is sampled with a faster system clock, so a phase-2 rate of 12.5 MHz is well within reach.

Top module: `bus_qualifier`

## Requirements
- R1: After reset, and before any low phase of phase-2 has been sampled, the captured bank byte (`full_addr[23:16]`) is 0x00.
- R2: On every system clock edge where `phi2` is low, the bank register loads `data_in`. While `phi2` is high, the bank register holds its value and ignores changes on `data_in`. `full_addr` is {bank, `addr_lo`} and `sram_addr` is `full_addr[19:0]`.
- R3: When `vda` and `vpa` are both low, `sel_sram`, `sel_rom` and `sel_io` are all 0.
- R4: When `be` is low, all selects, `rd_en`, `wr_en` and `to_cpu` are 0, whatever the levels on the other inputs.
- R5: The I/O select asserts for bank 0x00 with `addr_lo[15:8]` equal to 0xFE, when the address is qualified.
- R6: The ROM select asserts for bank 0x00 with `addr_lo[15:8]` equal to 0xFF, when the address is qualified.
- R7: The SRAM select asserts for banks 0x00 to 0x0F at any other qualified address.
- R8: Banks 0x10 and above select nothing.
- R9: At most one of the three selects is 1 at any time.
- R10: `rd_en` is 1 only when `phi2` is high, `rwb` is high and a select is active.
- R11: `wr_en` is 1 only when `phi2` is high, `rwb` is low and a select is active. It falls when `phi2` falls.
- R12: `to_cpu` (1 means the transceiver drives toward the processor) is 1 exactly when `rd_en` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample phase-2 and the bank byte |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | Processor phase-2 clock level |
| be | input | 1 | Bus enable; low means the processor buses float |
| vda | input | 1 | Valid data address strobe |
| vpa | input | 1 | Valid program address strobe |
| rwb | input | 1 | 1 read, 0 write |
| addr_lo | input | 16 | Processor address lines 0 to 15 |
| data_in | input | 8 | Processor data bus as seen by the glue |
| full_addr | output | 24 | Bank byte joined with the address lines |
| sram_addr | output | 20 | SRAM address |
| sel_sram | output | 1 | SRAM select |
| sel_rom | output | 1 | Boot ROM select |
| sel_io | output | 1 | I/O page select |
| rd_en | output | 1 | Read output enable toward the selected device |
| wr_en | output | 1 | Write enable toward the selected device |
| to_cpu | output | 1 | Transceiver direction, 1 toward the processor |

## Verification
The hardest case to reach is a bank byte that must survive the high phase while the data bus carries unrelated values. Every bench cycle places the bank on `data_in` during the low phase and then replaces it with random data as `phi2` rises. The held bank is compared only after that swap. Directed cycles also hit the page edges 0xFDFF, 0xFE00, 0xFEFF, 0xFF00 and the bank edge 0x0F/0x10 with both strobes low and with `be` low. Random cycles then cover all combinations.

// File: rtl/bus_qualifier_pkg.sv
package bus_qualifier_pkg;
  localparam int BANK_W = 8;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;

  typedef struct packed {
    logic io;
    logic rom;
    logic sram;
  } region_sel_t;
endpackage

// File: rtl/bank_capture.sv
module bank_capture #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [BANK_W-1:0] data_in,
  output logic [BANK_W-1:0] bank
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;
  logic              load_en;

  always_comb begin
    load_en = ~phi2;
    bank_d  = load_en ? data_in : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank = bank_q;
endmodule

// File: rtl/region_decode.sv
module region_decode
  import bus_qualifier_pkg::*;
#(
  parameter int               SRAM_BANKS = 16,
  parameter logic [PAGE_W-1:0] IO_PAGE   = 8'hFE,
  parameter logic [PAGE_W-1:0] ROM_PAGE  = 8'hFF
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              qualified,
  output region_sel_t       sel
);
  localparam int PAGE_LSB = ADDR_W - PAGE_W;

  logic               boot_bank;
  logic               in_sram;
  logic [PAGE_W-1:0]  page;

  always_comb begin
    page      = addr[ADDR_W-1:PAGE_LSB];
    boot_bank = (bank == '0);
    in_sram   = (int'(bank) < SRAM_BANKS);
    sel       = '0;
    if (qualified) begin
      if (boot_bank && page == IO_PAGE)       sel.io   = 1'b1;
      else if (boot_bank && page == ROM_PAGE) sel.rom  = 1'b1;
      else if (in_sram)                       sel.sram = 1'b1;
    end
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen
  import bus_qualifier_pkg::*;
(
  input  region_sel_t sel,
  input  logic        phi2,
  input  logic        rwb,
  input  logic        be,
  output logic        rd_en,
  output logic        wr_en,
  output logic        to_cpu
);
  logic active;

  always_comb begin
    active = (|sel) & phi2 & be;
    rd_en  = active & rwb;
    wr_en  = active & ~rwb;
    to_cpu = rd_en;
  end
endmodule

// File: rtl/bus_qualifier.sv
module bus_qualifier
  import bus_qualifier_pkg::*;
#(
  parameter int SRAM_BANKS = 16,
  parameter int SRAM_AW    = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phi2,
  input  logic                       be,
  input  logic                       vda,
  input  logic                       vpa,
  input  logic                       rwb,
  input  logic [15:0]                addr_lo,
  input  logic [7:0]                 data_in,
  output logic [23:0]                full_addr,
  output logic [SRAM_AW-1:0]         sram_addr,
  output logic                       sel_sram,
  output logic                       sel_rom,
  output logic                       sel_io,
  output logic                       rd_en,
  output logic                       wr_en,
  output logic                       to_cpu
);
  logic [BANK_W-1:0] bank;
  logic              qualified;
  region_sel_t       sel;

  bank_capture #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .data_in(data_in), .bank(bank)
  );

  always_comb qualified = be & (vda | vpa);

  region_decode #(.SRAM_BANKS(SRAM_BANKS)) u_dec (
    .bank(bank), .addr(addr_lo), .qualified(qualified), .sel(sel)
  );

  strobe_gen u_strb (
    .sel(sel), .phi2(phi2), .rwb(rwb), .be(be),
    .rd_en(rd_en), .wr_en(wr_en), .to_cpu(to_cpu)
  );

  always_comb begin
    full_addr = {bank, addr_lo};
    sram_addr = full_addr[SRAM_AW-1:0];
    sel_sram  = sel.sram;
    sel_rom   = sel.rom;
    sel_io    = sel.io;
  end
endmodule

// File: rtl/bus_qualifier_chk.sv
module bus_qualifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phi2,
  input logic        be,
  input logic        vda,
  input logic        vpa,
  input logic        rwb,
  input logic [23:0] full_addr,
  input logic        sel_sram,
  input logic        sel_rom,
  input logic        sel_io,
  input logic        rd_en,
  input logic        wr_en,
  input logic        to_cpu
);
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && $past(phi2)) |-> $stable(full_addr[23:16]));
  assert_no_strobe_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!vda && !vpa) |-> !(sel_sram || sel_rom || sel_io));
  assert_float_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !be |-> !(sel_sram || sel_rom || sel_io || rd_en || wr_en || to_cpu));
  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_sram, sel_rom, sel_io}));
  assert_read_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (phi2 && rwb));
  assert_write_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (phi2 && !rwb && !rd_en));
  assert_dir_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    to_cpu |-> (rwb && phi2 && (sel_sram || sel_rom || sel_io)));
endmodule

bind bus_qualifier bus_qualifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .be(be), .vda(vda), .vpa(vpa),
  .rwb(rwb), .full_addr(full_addr), .sel_sram(sel_sram), .sel_rom(sel_rom),
  .sel_io(sel_io), .rd_en(rd_en), .wr_en(wr_en), .to_cpu(to_cpu)
);

// File: tb/sim_bus_qualifier.sv
module sim_bus_qualifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        phi2, be, vda, vpa, rwb;
  logic [15:0] addr_lo;
  logic [7:0]  data_in;
  logic [23:0] full_addr;
  logic [19:0] sram_addr;
  logic        sel_sram, sel_rom, sel_io, rd_en, wr_en, to_cpu;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [7:0]  bank;
    logic [15:0] addr;
    logic [2:0]  sel;
    logic        rd, wr;
  } exp_t;
  exp_t q[$];
  event chk_ev;

  always #5 clk = ~clk;

  bus_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .be(be), .vda(vda), .vpa(vpa),
    .rwb(rwb), .addr_lo(addr_lo), .data_in(data_in), .full_addr(full_addr),
    .sram_addr(sram_addr), .sel_sram(sel_sram), .sel_rom(sel_rom),
    .sel_io(sel_io), .rd_en(rd_en), .wr_en(wr_en), .to_cpu(to_cpu)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected selects {io, rom, sram} from the address map
  function automatic logic [2:0] model_sel(logic [7:0] b, logic [15:0] a,
                                           logic v_d, logic v_p, logic e);
    if (!e || !(v_d || v_p)) return 3'b000;
    if (b == 8'h00 && a[15:8] == 8'hFE) return 3'b100;
    if (b == 8'h00 && a[15:8] == 8'hFF) return 3'b010;
    if (b < 8'h10) return 3'b001;
    return 3'b000;
  endfunction

  task automatic bus_cycle(string tag, logic [7:0] b, logic [15:0] a,
                           logic v_d, logic v_p, logic r, logic e);
    exp_t it;
    logic [2:0] s;
    @(negedge clk);
    phi2 = 1'b0; data_in = b; addr_lo = a; vda = v_d; vpa = v_p; rwb = r; be = e;
    @(negedge clk);
    check("R10 rd_en low phase", rd_en, 0);
    check("R11 wr_en low phase", wr_en, 0);
    check("R2 bank load", full_addr[23:16], b);
    @(negedge clk);
    phi2 = 1'b1; data_in = $urandom;
    s = model_sel(b, a, v_d, v_p, e);
    it.tag = tag; it.bank = b; it.addr = a; it.sel = s;
    it.rd = (s != 0) && r;
    it.wr = (s != 0) && !r;
    q.push_back(it);
    @(posedge clk);
    data_in = $urandom;
    #2 -> chk_ev;
    #1;
  endtask

  initial begin : monitor
    exp_t it;
    forever begin
      @(chk_ev);
      it = q.pop_front();
      check({it.tag, " R2 bank held"}, full_addr, {it.bank, it.addr});
      check({it.tag, " R7 sram_addr"}, sram_addr, {it.bank[3:0], it.addr});
      check({it.tag, " R9 selects"}, {sel_io, sel_rom, sel_sram}, it.sel);
      check({it.tag, " R10 rd_en"}, rd_en, it.rd);
      check({it.tag, " R11 wr_en"}, wr_en, it.wr);
      check({it.tag, " R12 to_cpu"}, to_cpu, it.rd);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; phi2 = 1'b1; be = 1'b1; vda = 1'b0; vpa = 1'b0; rwb = 1'b1;
    addr_lo = 16'h1234; data_in = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset bank", full_addr[23:16], 8'h00);
    check("R1 reset selects", {sel_io, sel_rom, sel_sram, rd_en, wr_en}, 0);

    bus_cycle("R5 io low edge",   8'h00, 16'hFE00, 1, 0, 1, 1);
    bus_cycle("R5 io high edge",  8'h00, 16'hFEFF, 0, 1, 0, 1);
    bus_cycle("R6 rom low edge",  8'h00, 16'hFF00, 1, 1, 1, 1);
    bus_cycle("R6 rom top",       8'h00, 16'hFFFF, 0, 1, 1, 1);
    bus_cycle("R7 below io page", 8'h00, 16'hFDFF, 1, 0, 0, 1);
    bus_cycle("R7 bank 0F",       8'h0F, 16'hFF10, 1, 0, 1, 1);
    bus_cycle("R7 bank 01 FE",    8'h01, 16'hFE00, 1, 0, 0, 1);
    bus_cycle("R8 bank 10",       8'h10, 16'h0000, 1, 1, 1, 1);
    bus_cycle("R8 bank FF",       8'hFF, 16'hFF00, 1, 0, 0, 1);
    bus_cycle("R3 no strobe",     8'h00, 16'hFF00, 0, 0, 1, 1);
    bus_cycle("R3 no strobe wr",  8'h03, 16'h4000, 0, 0, 0, 1);
    bus_cycle("R4 float read",    8'h00, 16'hFE10, 1, 1, 1, 0);
    bus_cycle("R4 float write",   8'h02, 16'h0100, 1, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [7:0]  b;
      logic [15:0] a;
      b = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom % 24);
      a = ($urandom % 2 == 0) ? {8'hFE + 8'($urandom % 2), 8'($urandom)} : 16'($urandom);
      bus_cycle("R9 random", b, a, 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 5) != 0);
    end

    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    check("R11 wr_en falls with phi2", wr_en, 0);
    check("R12 to_cpu low phase", to_cpu, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule